// File: doc/BRIEF.md
# Reloading Down-Counter Timer Bank

This block holds three reloading down-counters and one wide free-running up-counter behind a small word-addressed register port. Two of the down-counters are 16 bits wide and the third is 32 bits. Each one counts down on the tick strobe that its control word picks. When it passes zero it either reloads from its load register (periodic mode) or wraps to all ones. In both cases it raises a level interrupt, which stays high until software writes to that counter's clear register.

The free-running counter is 40 bits wide. It advances on the fast tick strobe while enabled. A bit in its high word turns it on, and it has no interrupt. Software typically uses one down-counter in periodic mode as the system heartbeat and reads the free-running counter to measure elapsed time between heartbeats. Both count rates arrive as single-cycle tick-enable inputs produced elsewhere.

Top module: `tick_timer_bank`

## Requirements
- R1: After reset every down-counter value, load and control word is zero, every interrupt is low, and the free-running counter reads zero and is disabled.
- R2: A down-counter decrements by one on each selected tick only while control bit 7 (run) is set. While run is clear, its value does not change on any tick.
- R3: Control bit 3 selects the tick source. When it is 1 the counter steps only on `slow_tick`; when it is 0 it steps only on `fast_tick`. The other strobe has no effect.
- R4: With control bit 6 (periodic) set, the tick that finds the value at zero loads the load register into the counter and raises its interrupt. The period is therefore load + 1 ticks.
- R5: With periodic clear, the tick that finds the value at zero wraps it to all ones at the counter's own width: 0xFFFF for counters 0 and 1, 0xFFFFFFFF for counter 2. That tick also raises the interrupt.
- R6: A write to the load register while run is clear also copies the value into the counter. While run is set, the write changes only the load register, and the value is unchanged until the next reload.
- R7: An interrupt is a level that stays high after underflow until the counter's clear register is written. Any write data clears it, and an underflow in the same cycle keeps it set.
- R8: The free-running counter adds one per `fast_tick` while enabled. It ignores `slow_tick` and never drives any interrupt.
- R9: A write to the free-running high word loads its enable from data bit 8. Writing bit 8 as 0 also zeroes the count. The high word reads back the enable in bit 8 and count bits 39:32 in bits 7:0. The low word reads count bits 31:0.
- R10: Word addresses are as follows. Counter i (0..2) uses word 4*i+0 for load, 4*i+1 for value (live count, read only), 4*i+2 for control and 4*i+3 for clear. The free-running low word is at 12 and the high word at 13. Control reads back with only bits 7, 6 and 3 populated.
- R11: A read presented with `rd_en` returns its data on `rdata` in the next cycle, with `rvalid` high for that one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slow_tick | input | 1 | Slow-rate count enable strobe |
| fast_tick | input | 1 | Fast-rate count enable strobe |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 4 | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid with rvalid |
| rvalid | output | 1 | Read data valid |
| irq | output | 3 | Level interrupts of the three down-counters |

## Verification
The bench uses the default widths: 16, 16 and 32 bits for the down-counters and 40 bits for the free-running counter. With these widths, loading zero and giving a single tick makes both the 16-bit and the 32-bit wrap values visible within a few cycles, so the width-dependent wrap of R5 is checked on two different counter sizes. A carry from bit 31 into the free-running high byte would need 2^32 ticks, so the high word is checked only for its enable bit and its zero upper byte.

// File: rtl/timer_bank_pkg.sv
package timer_bank_pkg;

  // register slot inside a down-counter's group of four words
  typedef enum logic [1:0] {
    SEL_LOAD  = 2'd0,
    SEL_VALUE = 2'd1,
    SEL_CTRL  = 2'd2,
    SEL_CLEAR = 2'd3
  } reg_sel_e;

  localparam int RUN_BIT      = 7;
  localparam int PERIODIC_BIT = 6;
  localparam int SLOW_BIT     = 3;
  localparam int FREE_EN_BIT  = 8;

  localparam logic [1:0] FREE_SLOT = 2'd3;
  localparam logic [1:0] FREE_LOW  = 2'd0;
  localparam logic [1:0] FREE_HIGH = 2'd1;

  typedef struct packed {
    logic run;
    logic periodic;
    logic slow;
  } ctrl_t;

  function automatic ctrl_t ctrl_from_word(input logic [7:0] w);
    ctrl_t c;
    c.run      = w[RUN_BIT];
    c.periodic = w[PERIODIC_BIT];
    c.slow     = w[SLOW_BIT];
    return c;
  endfunction

  function automatic logic [7:0] ctrl_to_word(input ctrl_t c);
    logic [7:0] w;
    w               = '0;
    w[RUN_BIT]      = c.run;
    w[PERIODIC_BIT] = c.periodic;
    w[SLOW_BIT]     = c.slow;
    return w;
  endfunction

endpackage

// File: rtl/reload_ctr.sv
module reload_ctr
  import timer_bank_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         slow_tick,
  input  logic         fast_tick,
  input  logic         load_wr,
  input  logic         ctrl_wr,
  input  logic         clear_wr,
  input  logic [W-1:0] wr_val,
  input  ctrl_t        ctrl_in,
  output logic [W-1:0] count,
  output logic [W-1:0] load_q,
  output ctrl_t        ctrl_q,
  output logic         irq
);

  // next value after one counting step
  function automatic logic [W-1:0] step_value(input logic [W-1:0] cur,
                                               input logic [W-1:0] reload,
                                               input logic         periodic);
    if (cur == '0) return periodic ? reload : '1;
    return cur - W'(1);
  endfunction

  logic step;
  logic underflow;

  assign step      = ctrl_q.run && (ctrl_q.slow ? slow_tick : fast_tick);
  assign underflow = step && (count == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      load_q <= '0;
      ctrl_q <= '0;
    end else begin
      if (load_wr) load_q <= wr_val;
      if (ctrl_wr) ctrl_q <= ctrl_in;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                     count <= '0;
    else if (load_wr && !ctrl_q.run) count <= wr_val;
    else if (step)                   count <= step_value(count, load_q, ctrl_q.periodic);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         irq <= 1'b0;
    else if (underflow) irq <= 1'b1;
    else if (clear_wr)  irq <= 1'b0;
  end

  // R2
  hold_when_stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q.run && !load_wr) |=> $stable(count));

  // R4
  periodic_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (underflow && ctrl_q.periodic) |=> (count == $past(load_q)));

  // R5
  wrap_all_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (underflow && !ctrl_q.periodic) |=> (count == '1));

  // R7
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(underflow));

  // R7
  irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_wr && !underflow) |=> !irq);

endmodule

// File: rtl/free_ctr.sv
module free_ctr #(
  parameter int W = 40
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         fast_tick,
  input  logic         high_wr,
  input  logic         en_in,
  output logic [W-1:0] count,
  output logic         en
);

  function automatic logic [W-1:0] bump(input logic [W-1:0] cur);
    return cur + W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)                 en <= 1'b0;
    else if (high_wr)           en <= en_in;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                  count <= '0;
    else if (high_wr && !en_in)  count <= '0;
    else if (en && fast_tick)    count <= bump(count);
  end

  // R8
  free_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && fast_tick && !high_wr) |=> (count == $past(count) + W'(1)));

  // R8
  free_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !high_wr) |=> $stable(count));

  // R9
  free_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (high_wr && !en_in) |=> (count == '0 && !en));

endmodule

// File: rtl/tick_timer_bank.sv
module tick_timer_bank
  import timer_bank_pkg::*;
#(
  parameter int W0     = 16,
  parameter int W1     = 16,
  parameter int W2     = 32,
  parameter int FREE_W = 40,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slow_tick,
  input  logic              fast_tick,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid,
  output logic [2:0]        irq
);

  localparam int NCTR = 3;
  localparam int HI_W = FREE_W - DATA_W;

  logic [1:0] slot;
  reg_sel_e   sel;
  assign slot = addr[3:2];
  assign sel  = reg_sel_e'(addr[1:0]);

  logic [DATA_W-1:0] cnt_ext  [NCTR];
  logic [DATA_W-1:0] load_ext [NCTR];
  ctrl_t             ctrl_v   [NCTR];
  ctrl_t             ctrl_new;

  assign ctrl_new = ctrl_from_word(wdata[7:0]);

  for (genvar i = 0; i < NCTR; i++) begin : g_ctr
    localparam int WI = (i == 0) ? W0 : (i == 1) ? W1 : W2;
    logic          hit;
    logic [WI-1:0] cnt_w;
    logic [WI-1:0] load_w;

    assign hit = wr_en && (slot == 2'(i));

    reload_ctr #(.W(WI)) u_ctr (
      .clk      (clk),
      .rst_n    (rst_n),
      .slow_tick(slow_tick),
      .fast_tick(fast_tick),
      .load_wr  (hit && sel == SEL_LOAD),
      .ctrl_wr  (hit && sel == SEL_CTRL),
      .clear_wr (hit && sel == SEL_CLEAR),
      .wr_val   (wdata[WI-1:0]),
      .ctrl_in  (ctrl_new),
      .count    (cnt_w),
      .load_q   (load_w),
      .ctrl_q   (ctrl_v[i]),
      .irq      (irq[i])
    );

    assign cnt_ext[i]  = DATA_W'(cnt_w);
    assign load_ext[i] = DATA_W'(load_w);
  end

  logic [FREE_W-1:0] free_cnt;
  logic              free_en;

  free_ctr #(.W(FREE_W)) u_free (
    .clk      (clk),
    .rst_n    (rst_n),
    .fast_tick(fast_tick),
    .high_wr  (wr_en && slot == FREE_SLOT && addr[1:0] == FREE_HIGH),
    .en_in    (wdata[FREE_EN_BIT]),
    .count    (free_cnt),
    .en       (free_en)
  );

  logic [DATA_W-1:0] rd_word;

  always_comb begin
    rd_word = '0;
    if (slot == FREE_SLOT) begin
      if (addr[1:0] == FREE_LOW)
        rd_word = free_cnt[DATA_W-1:0];
      else if (addr[1:0] == FREE_HIGH) begin
        rd_word[FREE_EN_BIT] = free_en;
        rd_word[HI_W-1:0]    = free_cnt[FREE_W-1:DATA_W];
      end
    end else begin
      case (sel)
        SEL_LOAD:  rd_word = load_ext[slot];
        SEL_VALUE: rd_word = cnt_ext[slot];
        SEL_CTRL:  rd_word = DATA_W'(ctrl_to_word(ctrl_v[slot]));
        default:   rd_word = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= rd_en;
      if (rd_en) rdata <= rd_word;
    end
  end

  // R11
  read_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rvalid);

  // R11
  read_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rvalid);

endmodule

// File: tb/tick_timer_bank_tb.sv
`timescale 1ns/1ps
module tick_timer_bank_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        slow_tick = 1'b0;
  logic        fast_tick = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rvalid;
  logic [2:0]  irq;

  always #2.5 clk = ~clk;

  tick_timer_bank u_dut (
    .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .fast_tick(fast_tick),
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .rvalid(rvalid), .irq(irq)
  );

  typedef struct {
    logic [31:0] exp;
    logic [3:0]  a;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_vec = 0;
  int   n_bad = 0;
  bit   done  = 0;

  // monitor: compare read data as it comes out
  always @(negedge clk) begin
    if (rvalid) begin
      n_vec++;
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL unexpected read data: actual %h expected none", rdata);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        if (rdata !== e.exp) begin
          n_bad++;
          $display("FAIL %s word %0d: actual %h expected %h", e.tag, e.a, rdata, e.exp);
        end
      end
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [31:0] e, input string tag);
    exp_q.push_back('{e, a, tag});
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic slow(input int n);
    for (int k = 0; k < n; k++) begin
      slow_tick = 1'b1; @(negedge clk); slow_tick = 1'b0;
    end
  endtask

  task automatic fast(input int n);
    for (int k = 0; k < n; k++) begin
      fast_tick = 1'b1; @(negedge clk); fast_tick = 1'b0;
    end
  endtask

  task automatic chk_irq(input logic [2:0] e, input string tag);
    n_vec++;
    if (irq !== e) begin
      n_bad++;
      $display("FAIL %s irq: actual %b expected %b", tag, irq, e);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk_irq(3'b000, "R1 reset");
    rd(4'd1, 32'h0, "R1 value0");
    rd(4'd2, 32'h0, "R1 ctrl0");
    rd(4'd12, 32'h0, "R1 free low");
    rd(4'd13, 32'h0, "R1 free high");

    // R6 load while stopped copies; R2 stopped holds
    wr(4'd2, 32'h48);
    rd(4'd2, 32'hC8 & 32'h48, "R10 ctrl readback stopped");
    wr(4'd0, 32'd4);
    rd(4'd1, 32'd4, "R6 load copy while stopped");
    slow(3);
    rd(4'd1, 32'd4, "R2 hold while stopped");

    // R4 periodic: period load+1
    wr(4'd2, 32'hC8);
    rd(4'd2, 32'hC8, "R10 ctrl readback running");
    slow(4);
    rd(4'd1, 32'd0, "R2 counted down to zero");
    chk_irq(3'b000, "R4 no irq before underflow");
    slow(1);
    rd(4'd1, 32'd4, "R4 reload on underflow");
    chk_irq(3'b001, "R4 irq on underflow");

    // R3 fast strobe ignored with slow selected
    fast(2);
    rd(4'd1, 32'd4, "R3 other strobe ignored");
    chk_irq(3'b001, "R7 irq held");

    // R7 clear by any write
    wr(4'd3, 32'h0);
    chk_irq(3'b000, "R7 clear write");

    // R5 wrap, R6 load while running, R3 fast select
    wr(4'd2, 32'h80);
    wr(4'd0, 32'd9);
    rd(4'd1, 32'd4, "R6 running load leaves value");
    rd(4'd0, 32'd9, "R6 load register updated");
    fast(4);
    chk_irq(3'b000, "R5 no irq at zero");
    fast(1);
    rd(4'd1, 32'h0000FFFF, "R5 16-bit wrap");
    chk_irq(3'b001, "R5 irq on wrap");
    fast(1);
    rd(4'd1, 32'h0000FFFE, "R2 decrement after wrap");
    slow(2);
    rd(4'd1, 32'h0000FFFE, "R3 slow ignored with fast selected");

    wr(4'd2, 32'h00);
    wr(4'd3, 32'hDEAD);
    chk_irq(3'b000, "R7 clear with arbitrary data");

    // counter 2, 32 bits
    wr(4'd10, 32'h40);
    wr(4'd8, 32'd2);
    wr(4'd10, 32'hC0);
    fast(3);
    rd(4'd9, 32'd2, "R4 counter2 reload");
    chk_irq(3'b100, "R4 counter2 irq");
    wr(4'd10, 32'h00);
    wr(4'd8, 32'd0);
    wr(4'd10, 32'h80);
    fast(1);
    rd(4'd9, 32'hFFFFFFFF, "R5 32-bit wrap");
    wr(4'd11, 32'h1);
    chk_irq(3'b000, "R7 counter2 clear");

    // R8 / R9 free-running counter
    wr(4'd13, 32'h100);
    rd(4'd13, 32'h100, "R9 enable readback");
    fast(3);
    rd(4'd12, 32'd3, "R8 free counts fast ticks");
    slow(2);
    rd(4'd12, 32'd3, "R8 free ignores slow ticks");
    chk_irq(3'b000, "R8 free never interrupts");
    wr(4'd13, 32'h0);
    rd(4'd12, 32'd0, "R9 disable zeroes count");
    rd(4'd13, 32'd0, "R9 high word after disable");
    fast(2);
    rd(4'd12, 32'd0, "R8 stopped free holds");

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      n_bad++;
      $display("FAIL R11 pending reads: actual %0d expected 0", exp_q.size());
    end
    done = 1;
    summary();
    $finish;
  end

endmodule